// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block is a shared scratchpad of 32-bit words, spread across 16 interleaved banks. A client presents a group of 16 lane requests in one cycle. Each lane carries a word address, an active flag and write data, and one flag marks the whole group as a read or a write. The block works out which active lanes land in the same bank. It then runs the group through the banks in as few two-cycle passes as the collisions allow.

In each pass, every bank takes the lowest-numbered lane still waiting on it. All other waiting lanes with exactly the same address ride along in that pass, so one word is broadcast to every lane that asked for it. When the last lane is served, a one-cycle done pulse is raised. Per-lane read data and the number of passes the group cost are valid with that pulse and stay until the next group is accepted. A new group is taken only while the block is idle.

Top module: `smem_serializer`

## Requirements
- R1: A word address splits into a bank index (address bits [3:0]) and a row (bits [7:4]), and a word written to an address is returned by a later read of that address.
- R2: One pass takes two cycles. For a group that needs P passes (P ≥ 1), `done` is high for exactly one cycle, sampled 2·P clock edges after the accepting edge, and `req_ready` is high again in the cycle after `done`.
- R3: A group whose active lanes all sit in different banks finishes in one pass (`pass_count` = 1).
- R4: A group whose active lanes all use one address finishes in one pass, and every active lane receives that word.
- R5: Lanes in one bank at different addresses are served in separate passes, and `pass_count` equals the largest number of distinct addresses requested in any one bank. Lane strides of 2, 8 and 16 give 2, 8 and 16 passes.
- R6: Any odd lane stride, with stride 1 included, finishes in one pass.
- R7: When several active lanes of a write group name the same address, the data of the highest-numbered such lane is stored. A write group returns zero on every lane of `rd_data`.
- R8: Inactive lanes return zero read data and do not change memory. A group with no active lane gives `done` one edge after acceptance, with `pass_count` = 0.
- R9: `req_ready` is low while a group is in progress, and a `req_valid` raised during that time is ignored.
- R10: After reset, `req_ready` = 1, `done` = 0, `pass_count` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Presents a request group; taken when `req_ready` is high |
| req_write | input | 1 | 1 = write group, 0 = read group |
| req_active | input | 16 | Per-lane active flag, bit i for lane i |
| req_addr | input | 128 | Lane i word address in bits [8i+7:8i] |
| req_wdata | input | 512 | Lane i write data in bits [32i+31:32i] |
| req_ready | output | 1 | High when idle and able to take a group |
| done | output | 1 | One-cycle pulse when the group is fully served |
| pass_count | output | 5 | Passes used by the last group |
| rd_data | output | 512 | Lane i read data in bits [32i+31:32i] |

## Verification
The assertions check, on every cycle, the properties that hold pass by pass. A bank's merged lanes are all waiting and all map to that bank. Every access pass removes at least one waiting lane and adds none. `done` lasts a single cycle and leads straight back to idle, and the reported pass count never exceeds the lane count. Only the bench's scenarios can show the end-to-end results: the exact pass counts for the strides and the broadcast case, the latency of 2·P, the data actually returned, the winner among colliding writes, and the fact that inactive lanes and requests made while busy leave memory untouched.

// File: rtl/smem_pkg.sv
package smem_pkg;
    parameter int LANES   = 16;
    parameter int BANKS   = 16;
    parameter int WORD_W  = 32;
    parameter int ADDR_W  = 8;
    parameter int BANK_W  = $clog2(BANKS);
    parameter int ROW_W   = ADDR_W - BANK_W;
    parameter int ROWS    = 2 ** ROW_W;
    parameter int LANE_W  = $clog2(LANES);
    parameter int CNT_W   = $clog2(LANES + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [LANES-1:0]  lane_mask_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_ACC  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic              valid;
        row_t              row;
        lane_mask_t        lanes;
        logic [LANE_W-1:0] wr_lane;
    } bank_pick_t;

    function automatic bank_t bank_of(input addr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic row_t row_of(input addr_t a);
        return a[ADDR_W-1:BANK_W];
    endfunction
endpackage

// File: rtl/smem_bank.sv
module smem_bank
    import smem_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  row_t  row,
    input  word_t wdata,
    output word_t rdata
);
    word_t store [ROWS];

    always_ff @(posedge clk) begin
        if (we) store[row] <= wdata;
    end

    assign rdata = store[row];
endmodule

// File: rtl/smem_bank_pick.sv
module smem_bank_pick
    import smem_pkg::*;
#(
    parameter int BANK_IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  lane_mask_t pending,
    input  addr_t      addrs [LANES],
    output bank_pick_t pick
);
    addr_t lead;
    logic  found;

    always_comb begin
        pick  = '0;
        lead  = '0;
        found = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (!found && pending[l] && bank_of(addrs[l]) == BANK_W'(BANK_IDX)) begin
                found = 1'b1;
                lead  = addrs[l];
            end
        end
        pick.valid = found;
        pick.row   = row_of(lead);
        for (int l = 0; l < LANES; l++) begin
            if (found && pending[l] && addrs[l] == lead) begin
                pick.lanes[l] = 1'b1;
                pick.wr_lane  = LANE_W'(l);
            end
        end
    end

    // R5
    pick_subset_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> ((pick.lanes & ~pending) == '0) && (pick.lanes != '0))
        else $error("pick lanes not a nonempty subset of pending");

    // R1
    pick_bank_chk: assert property (@(posedge clk) disable iff (rst)
        pick.valid |-> (bank_of(addrs[pick.wr_lane]) == BANK_W'(BANK_IDX))
                       && pick.lanes[pick.wr_lane])
        else $error("picked lane outside its bank");
endmodule

// File: rtl/smem_seq_ctrl.sv
module smem_seq_ctrl
    import smem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  lane_mask_t req_active,
    input  lane_mask_t served,
    output logic       req_ready,
    output logic       accept,
    output logic       sel_en,
    output logic       acc_en,
    output lane_mask_t pending,
    output logic       done,
    output cnt_t       pass_count
);
    seq_state_e state_q;
    lane_mask_t pend_q;
    lane_mask_t pend_left;
    cnt_t       cnt_q;
    logic       done_q;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign sel_en     = (state_q == ST_SEL) && (pend_q != '0);
    assign acc_en     = (state_q == ST_ACC);
    assign pending    = pend_q;
    assign done       = done_q;
    assign pass_count = cnt_q;
    assign pend_left  = pend_q & ~served;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        pend_q  <= req_active;
                        cnt_q   <= '0;
                        state_q <= ST_SEL;
                    end
                end
                ST_SEL: begin
                    if (pend_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_ACC;
                    end
                end
                ST_ACC: begin
                    pend_q <= pend_left;
                    cnt_q  <= cnt_q + 1'b1;
                    if (pend_left == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_SEL;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && req_ready)
        else $error("done not a single-cycle pulse back to idle");

    // R5
    pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |=> ((pending & ~$past(pending)) == '0) && (pending != $past(pending)))
        else $error("access pass made no progress");

    // R5
    pass_bound_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> pass_count <= cnt_t'(LANES))
        else $error("pass count above lane count");

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !acc_en) |=> $stable(pending))
        else $error("request while busy disturbed pending lanes");
endmodule

// File: rtl/smem_serializer.sv
module smem_serializer
    import smem_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [LANES-1:0]        req_active,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic [LANES*WORD_W-1:0] req_wdata,
    output logic                    req_ready,
    output logic                    done,
    output logic [CNT_W-1:0]        pass_count,
    output logic [LANES*WORD_W-1:0] rd_data
);
    logic       accept, sel_en, acc_en;
    lane_mask_t pending;
    lane_mask_t served;
    logic       write_q;
    addr_t      addr_q  [LANES];
    word_t      wdata_q [LANES];
    word_t      rdata_q [LANES];
    bank_pick_t pick    [BANKS];
    bank_pick_t pick_q  [BANKS];
    word_t      bank_rd [BANKS];

    smem_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_active (req_active),
        .served     (served),
        .req_ready  (req_ready),
        .accept     (accept),
        .sel_en     (sel_en),
        .acc_en     (acc_en),
        .pending    (pending),
        .done       (done),
        .pass_count (pass_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l]  <= '0;
                wdata_q[l] <= '0;
            end
        end else if (accept) begin
            write_q <= req_write;
            for (int l = 0; l < LANES; l++) begin
                addr_q[l]  <= req_addr[l*ADDR_W +: ADDR_W];
                wdata_q[l] <= req_wdata[l*WORD_W +: WORD_W];
            end
        end
    end

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            smem_bank_pick #(.BANK_IDX(b)) u_pick (
                .clk     (clk),
                .rst     (rst),
                .pending (pending),
                .addrs   (addr_q),
                .pick    (pick[b])
            );

            always_ff @(posedge clk) begin
                if (rst)         pick_q[b] <= '0;
                else if (sel_en) pick_q[b] <= pick[b];
            end

            smem_bank u_bank (
                .clk   (clk),
                .we    (acc_en && write_q && pick_q[b].valid),
                .row   (pick_q[b].row),
                .wdata (wdata_q[pick_q[b].wr_lane]),
                .rdata (bank_rd[b])
            );
        end
    endgenerate

    always_comb begin
        served = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (pick_q[b].valid) served = served | pick_q[b].lanes;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int l = 0; l < LANES; l++) rdata_q[l] <= '0;
        end else if (accept) begin
            for (int l = 0; l < LANES; l++) rdata_q[l] <= '0;
        end else if (acc_en && !write_q) begin
            for (int l = 0; l < LANES; l++) begin
                if (pick_q[bank_of(addr_q[l])].lanes[l])
                    rdata_q[l] <= bank_rd[bank_of(addr_q[l])];
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) rd_data[l*WORD_W +: WORD_W] = rdata_q[l];
    end

    // R5
    acc_progress_chk: assert property (@(posedge clk) disable iff (rst)
        acc_en |-> ((served != '0) && ((served & ~pending) == '0)))
        else $error("access pass serves no pending lane");

    // R7
    write_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && write_q) |-> (rd_data == '0))
        else $error("write group returned read data");
endmodule

// File: tb/smem_serializer_tb.sv
module smem_serializer_tb;
    import smem_pkg::*;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    req_valid;
    logic                    req_write;
    logic [LANES-1:0]        req_active;
    logic [LANES*ADDR_W-1:0] req_addr;
    logic [LANES*WORD_W-1:0] req_wdata;
    logic                    req_ready;
    logic                    done;
    logic [CNT_W-1:0]        pass_count;
    logic [LANES*WORD_W-1:0] rd_data;

    int tests  = 0;
    int failed = 0;

    logic [7:0]  t_addr  [16];
    logic [31:0] t_wdata [16];
    logic [15:0] t_act;
    logic        t_wr;
    logic [31:0] ref_mem [256];

    always #4 clk = ~clk;

    smem_serializer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_active(req_active), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .pass_count(pass_count),
        .rd_data(rd_data)
    );

    task automatic chk(input logic ok, input string rq, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic drive_req();
        req_write  = t_wr;
        req_active = t_act;
        for (int i = 0; i < 16; i++) begin
            req_addr[i*8 +: 8]   = t_addr[i];
            req_wdata[i*32 +: 32] = t_wdata[i];
        end
    endtask

    task automatic set_stride(input int base, input int stride, input logic wr,
                              input logic [15:0] act);
        for (int i = 0; i < 16; i++) begin
            t_addr[i]  = 8'((base + stride * i) % 256);
            t_wdata[i] = 32'hC3000000 ^ (32'(base) << 12) ^ (32'(i) * 32'h00010101);
        end
        t_wr  = wr;
        t_act = act;
    endtask

    task automatic run_group(input string rq, input int exp_pass);
        int cyc;
        logic seen;
        logic [31:0] exp_rd [16];
        for (int i = 0; i < 16; i++)
            exp_rd[i] = (!t_wr && t_act[i]) ? ref_mem[t_addr[i]] : 32'h0;
        @(negedge clk);
        drive_req();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        seen = 1'b0;
        while (!seen && cyc < 100) begin
            @(posedge clk);
            #1;
            cyc++;
            if (done) seen = 1'b1;
        end
        chk(seen, rq, "done seen", seen, 1);
        chk(cyc == ((exp_pass == 0) ? 1 : 2 * exp_pass), "R2", {rq, " latency"},
            cyc, (exp_pass == 0) ? 1 : 2 * exp_pass);
        chk(pass_count == CNT_W'(exp_pass), rq, "pass_count", pass_count, exp_pass);
        for (int i = 0; i < 16; i++)
            chk(rd_data[i*32 +: 32] == exp_rd[i], rq, $sformatf("lane %0d data", i),
                rd_data[i*32 +: 32], exp_rd[i]);
        @(posedge clk);
        #1;
        chk(!done && req_ready, "R2", "done pulse width", {done, req_ready}, 2'b01);
        if (t_wr)
            for (int i = 0; i < 16; i++)
                if (t_act[i]) ref_mem[t_addr[i]] = t_wdata[i];
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
        chk(done == 1'b0, "R10", "done", done, 0);
        chk(pass_count == '0, "R10", "pass_count", pass_count, 0);
        chk(rd_data == '0, "R10", "rd_data zero", 0, 0);
    endtask

    task automatic t_fill();
        // R1 and R3: stride-1 writes touch 16 distinct banks
        for (int b = 0; b < 256; b += 16) begin
            set_stride(b, 1, 1'b1, 16'hFFFF);
            run_group("R3", 1);
        end
    endtask

    task automatic t_reads();
        set_stride(32, 1, 1'b0, 16'hFFFF);  run_group("R1", 1);
        set_stride(5, 3, 1'b0, 16'hFFFF);   run_group("R6", 1);
        set_stride(7, 7, 1'b0, 16'hFFFF);   run_group("R6", 1);
        set_stride(0, 2, 1'b0, 16'hFFFF);   run_group("R5", 2);
        set_stride(3, 8, 1'b0, 16'hFFFF);   run_group("R5", 8);
        set_stride(9, 16, 1'b0, 16'hFFFF);  run_group("R5", 16);
    endtask

    task automatic t_broadcast();
        set_stride(37, 0, 1'b0, 16'hFFFF);
        run_group("R4", 1);
        // lanes 0,1 share address 4, lane 2 uses 20 in the same bank
        set_stride(64, 1, 1'b0, 16'h0007);
        t_addr[0] = 8'd4; t_addr[1] = 8'd4; t_addr[2] = 8'd20;
        run_group("R4", 2);
    endtask

    task automatic t_write_collide();
        set_stride(50, 0, 1'b1, 16'hFFFF);
        run_group("R7", 1);
        set_stride(50, 0, 1'b0, 16'h0001);
        run_group("R7", 1);
        chk(rd_data[31:0] == (32'hC3000000 ^ (32'd50 << 12) ^ (32'd15 * 32'h00010101)),
            "R7", "highest lane wins", rd_data[31:0], ref_mem[50]);
    endtask

    task automatic t_inactive();
        set_stride(100, 1, 1'b0, 16'h00FF);  run_group("R8", 1);
        set_stride(200, 1, 1'b1, 16'h0F0F);
        for (int i = 0; i < 16; i++) t_wdata[i] = 32'h5A5A0000 + 32'(i);
        run_group("R8", 1);
        set_stride(200, 1, 1'b0, 16'hFFFF);  run_group("R8", 1);
        set_stride(0, 1, 1'b0, 16'h0000);    run_group("R8", 0);
    endtask

    task automatic t_busy();
        int cyc;
        set_stride(9, 16, 1'b0, 16'hFFFF);
        @(negedge clk);
        drive_req();
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9", "busy req_ready", req_ready, 0);
        set_stride(0, 0, 1'b1, 16'hFFFF);
        for (int i = 0; i < 16; i++) t_wdata[i] = 32'hDEAD0000;
        drive_req();
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            @(posedge clk);
            #1;
            cyc++;
        end
        chk(done, "R9", "first group completes", done, 1);
        @(posedge clk);
        set_stride(0, 1, 1'b0, 16'hFFFF);
        run_group("R9", 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failed++;
        tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_active = '0;
        req_addr = '0;
        req_wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_reads();
        t_broadcast();
        t_write_collide();
        t_inactive();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule